// File: doc/BRIEF.md
# Dual-Clock FIFO with Standard and Fall-Through Read Modes

This block is a 36-bit-wide first-in first-out buffer whose producer and consumer each run on their own clock. The two clocks may be unrelated or may be the very same net. A word enters on a rising write-clock edge while the write enable is high and the block has room. A word leaves on a rising read-clock edge while the read enable is high and data is available. Both pointers cross between the domains as gray code through two-flop synchronizers. The depth is a parameter and defaults to 1024 entries.

A static mode input selects how the read side behaves. In standard mode, every word has to be requested, and the read-side status shows whether the memory holds anything. In fall-through mode, the oldest word is moved onto the outputs without a request. The read-side status then means "a valid word is on the outputs", and each request retires that word.

Each side also has a programmable threshold flag: almost-empty on the read side and almost-full on the write side. While reset is held, a two-bit select chooses a fixed offset of 8, 16 or 64 for both flags. It can instead choose loading, in which case the first two writes after reset carry the two offsets.

Top module: `xfp_fifo`

## Requirements
- R1: While `rst_n` is low at rising clock edges, both pointers return to location zero. Once reset is released, `rd_ready`=0, `wr_ready`=1, `almost_empty`=1 and `almost_full`=0.
- R2: `ofs_sel` is sampled while `rst_n` is low. The code 2'b00 gives an offset of 8 to both flags, 2'b01 gives 16, and 2'b10 gives 64.
- R3: With `ofs_sel`=2'b11, the first write after reset loads the almost-empty offset from `wr_data[AW:0]` and the second loads the almost-full offset, where AW=log2(DEPTH). Neither of these writes enters the FIFO.
- R4: Words leave in the order they were written. A write is taken on a rising `wr_clk` edge when `wr_en` and `wr_ready` are both high. In standard mode, a read taken on a rising `rd_clk` edge (`rd_en` and `rd_ready` high) presents its word on `rd_data` right after that edge.
- R5: A write while `wr_ready` is low is ignored. It changes neither the stored words nor the pointers.
- R6: A read while `rd_ready` is low is ignored, and `rd_data` holds its value.
- R7: In standard mode, `rd_ready` means the memory is not empty. It rises on the second `rd_clk` edge after the write edge.
- R8: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with `rd_ready`=1 on the third read edge after the write, with no read request. The word is held until a read retires it. Total capacity is DEPTH+1 words.
- R9: `almost_empty` is high when the unread word count is at or below the almost-empty offset. In fall-through mode, that count includes the word on the outputs. The flag is produced in the read-clock domain.
- R10: `almost_full` is high when the free memory locations are at or below the almost-full offset. `wr_ready` is low when the memory holds DEPTH words. Both are produced in the write-clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low master reset, held across edges of both clocks |
| fwft_mode | input | 1 | 1 = fall-through mode, 0 = standard mode; static |
| ofs_sel | input | 2 | Offset select, sampled during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data, also carries loaded offsets |
| wr_ready | output | 1 | Room available (not full) |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read data |
| rd_ready | output | 1 | Standard: not empty; fall-through: valid word on outputs |
| almost_empty | output | 1 | Unread words at or below the almost-empty offset |

## Verification
A write becomes visible to the read side two read edges after its write edge, and in fall-through mode the word lands on the outputs one edge later. A read frees space on the write side two write edges after it is taken. One dedicated sequence samples `rd_ready` on the falling edge after each of the first four edges following a write, to pin those exact cycles in both modes. Every other flag and data check waits six clock periods after a single stimulus, so the synchronizers have settled and the expected values depend only on the word count that the bench tracks arithmetically.

// File: rtl/xfp_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes: offset select codes are sampled only while reset is held.
package xfp_pkg;

    localparam int WORD_W = 36;

    typedef enum logic [1:0] {
        OFS_8    = 2'b00,
        OFS_16   = 2'b01,
        OFS_64   = 2'b10,
        OFS_LOAD = 2'b11
    } ofs_sel_e;

    // Default threshold for a select code (load code falls back to 8).
    function automatic int unsigned dflt_ofs(input logic [1:0] sel);
        case (sel)
            OFS_16:  return 16;
            OFS_64:  return 64;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/xfp_gray_sync.sv
// Two-flop synchronizer for a gray-coded pointer.
// Assumes: the input changes by at most one bit per source clock edge.
module xfp_gray_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the foreign pointer through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xfp_ram.sv
// Simple dual-port storage: write on the write clock, registered read on
// the read clock. Assumes: the read side never addresses a location that
// is being written in the same period (guaranteed by the empty logic).
module xfp_ram #(
    parameter int DW = 36,
    parameter int AW = 10
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch the addressed word into the output register.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xfp_wr_ctl.sv
// Write-side control: write pointer, full and almost-full flags, and the
// threshold registers (defaults or loaded by the first two writes).
// Assumes: the loaded almost-empty offset is quasi-static and is only read
// by the other domain once data has crossed, i.e. after it has settled.
module xfp_wr_ctl import xfp_pkg::*; #(
    parameter int AW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  ofs_sel,
    input  logic        wr_en,
    input  logic [AW:0] wr_ofs_val,
    input  logic [AW:0] r_gray_s,
    output logic        we,
    output logic [AW-1:0] waddr,
    output logic [AW:0] w_bin,
    output logic [AW:0] w_gray,
    output logic        wr_ready,
    output logic        almost_full,
    output logic [AW:0] ae_ofs
);
    localparam int PW = AW + 1;
    localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

    logic [1:0]  load_left;
    logic [AW:0] af_ofs;
    logic [AW:0] r_bin_s;
    logic [AW:0] used;
    logic [AW:0] free_cnt;
    logic        full;
    logic        loading;
    logic [AW:0] w_bin_nx;

    // Convert the synchronized read pointer back to binary.
    always_comb begin
        r_bin_s[AW] = r_gray_s[AW];
        for (int i = AW - 1; i >= 0; i--) r_bin_s[i] = r_bin_s[i+1] ^ r_gray_s[i];
    end

    // Occupancy, free space and write acceptance.
    always_comb begin
        used        = w_bin - r_bin_s;
        free_cnt    = CAP - used;
        full        = (used == CAP);
        loading     = (load_left != 2'd0);
        wr_ready    = !full;
        almost_full = (free_cnt <= af_ofs);
        we          = rst_n && wr_en && !full && !loading;
        w_bin_nx    = w_bin + PW'(1);
        waddr       = w_bin[AW-1:0];
    end

    // Pointer advance and threshold selection or loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_bin     <= '0;
            w_gray    <= '0;
            ae_ofs    <= PW'(dflt_ofs(ofs_sel));
            af_ofs    <= PW'(dflt_ofs(ofs_sel));
            load_left <= (ofs_sel == OFS_LOAD) ? 2'd2 : 2'd0;
        end else begin
            if (we) begin
                w_bin  <= w_bin_nx;
                w_gray <= w_bin_nx ^ (w_bin_nx >> 1);
            end
            if (wr_en && loading) begin
                if (load_left == 2'd2) ae_ofs <= wr_ofs_val;
                else                   af_ofs <= wr_ofs_val;
                load_left <= load_left - 2'd1;
            end
        end
    end
endmodule

// File: rtl/xfp_rd_ctl.sv
// Read-side control: read pointer, empty detection, the fall-through
// output stage and the almost-empty flag.
// Assumes: fwft is static between resets; ae_ofs is quasi-static.
module xfp_rd_ctl #(
    parameter int AW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fwft,
    input  logic        rd_en,
    input  logic [AW:0] w_gray_s,
    input  logic [AW:0] ae_ofs,
    output logic        re,
    output logic [AW-1:0] raddr,
    output logic [AW:0] r_bin,
    output logic [AW:0] r_gray,
    output logic        rd_ready,
    output logic        almost_empty
);
    localparam int PW = AW + 1;
    localparam int LW = AW + 2;

    logic [AW:0] w_bin_s;
    logic [AW:0] r_bin_nx;
    logic [AW:0] mem_cnt;
    logic [LW-1:0] level;
    logic        mem_empty;
    logic        out_vld;

    // Convert the synchronized write pointer back to binary.
    always_comb begin
        w_bin_s[AW] = w_gray_s[AW];
        for (int i = AW - 1; i >= 0; i--) w_bin_s[i] = w_bin_s[i+1] ^ w_gray_s[i];
    end

    // Fetch decision, status and unread-word level.
    always_comb begin
        mem_empty    = (r_gray == w_gray_s);
        if (fwft) re = rst_n && !mem_empty && (!out_vld || rd_en);
        else      re = rst_n && !mem_empty && rd_en;
        rd_ready     = fwft ? out_vld : !mem_empty;
        mem_cnt      = w_bin_s - r_bin;
        level        = {1'b0, mem_cnt} + LW'(fwft && out_vld);
        almost_empty = (level <= {1'b0, ae_ofs});
        r_bin_nx     = r_bin + PW'(1);
        raddr        = r_bin[AW-1:0];
    end

    // Read pointer advance and fall-through valid tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_bin   <= '0;
            r_gray  <= '0;
            out_vld <= 1'b0;
        end else begin
            if (re) begin
                r_bin  <= r_bin_nx;
                r_gray <= r_bin_nx ^ (r_bin_nx >> 1);
            end
            if (re)                     out_vld <= 1'b1;
            else if (rd_en && out_vld)  out_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/xfp_fifo.sv
// Dual-clock FIFO with standard and fall-through read modes and
// programmable almost-empty / almost-full thresholds.
// Assumes: DEPTH is a power of two of at least 64; rst_n is held low across
// at least two edges of each clock; fwft_mode and ofs_sel change only in reset.
module xfp_fifo import xfp_pkg::*; #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = WORD_W
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             fwft_mode,
    input  logic [1:0]       ofs_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             almost_full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_ready,
    output logic             almost_empty
);
    localparam int AW = $clog2(DEPTH);

    logic          ram_we;
    logic          ram_re;
    logic [AW-1:0] ram_waddr;
    logic [AW-1:0] ram_raddr;
    logic [AW:0]   w_bin;
    logic [AW:0]   r_bin;
    logic [AW:0]   w_gray;
    logic [AW:0]   r_gray;
    logic [AW:0]   w_gray_s;
    logic [AW:0]   r_gray_s;
    logic [AW:0]   ae_ofs;

    xfp_wr_ctl #(.AW(AW)) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .ofs_sel    (ofs_sel),
        .wr_en      (wr_en),
        .wr_ofs_val (wr_data[AW:0]),
        .r_gray_s   (r_gray_s),
        .we         (ram_we),
        .waddr      (ram_waddr),
        .w_bin      (w_bin),
        .w_gray     (w_gray),
        .wr_ready   (wr_ready),
        .almost_full(almost_full),
        .ae_ofs     (ae_ofs)
    );

    xfp_rd_ctl #(.AW(AW)) u_rd (
        .clk         (rd_clk),
        .rst_n       (rst_n),
        .fwft        (fwft_mode),
        .rd_en       (rd_en),
        .w_gray_s    (w_gray_s),
        .ae_ofs      (ae_ofs),
        .re          (ram_re),
        .raddr       (ram_raddr),
        .r_bin       (r_bin),
        .r_gray      (r_gray),
        .rd_ready    (rd_ready),
        .almost_empty(almost_empty)
    );

    xfp_gray_sync #(.W(AW + 1)) u_w2r (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .d    (w_gray),
        .q    (w_gray_s)
    );

    xfp_gray_sync #(.W(AW + 1)) u_r2w (
        .clk  (wr_clk),
        .rst_n(rst_n),
        .d    (r_gray),
        .q    (r_gray_s)
    );

    xfp_ram #(.DW(WIDTH), .AW(AW)) u_ram (
        .wr_clk(wr_clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_data),
        .rd_clk(rd_clk),
        .rst_n (rst_n),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/xfp_fifo_chk.sv
// Property checker for xfp_fifo, attached by bind below.
// Assumes: signals are sampled at the edges of their own domain.
module xfp_fifo_chk #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          fwft_mode,
    input logic          wr_en,
    input logic          wr_ready,
    input logic          almost_full,
    input logic          rd_en,
    input logic          rd_ready,
    input logic          almost_empty,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   w_bin,
    input logic [AW:0]   r_bin,
    input logic [AW:0]   w_gray,
    input logic [AW:0]   r_gray
);
    // R1: pointers sit at zero when reset is released
    a_r1_wptr_reset: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (w_bin == '0));
    a_r1_rptr_reset: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r_bin == '0));

    // R5: write while full leaves the write pointer alone
    a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(w_bin));

    // R6: standard-mode read while empty changes nothing
    a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft_mode && rd_en && !rd_ready) |=> ($stable(r_bin) && $stable(rd_data)));

    // R8: fall-through word is held until it is read
    a_r8_fwft_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fwft_mode && rd_ready && !rd_en) |=> (rd_ready && $stable(rd_data)));

    // R9: an empty memory is always almost empty
    a_r9_empty_is_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft_mode && !rd_ready) |-> almost_empty);

    // R10: a full memory is always almost full
    a_r10_full_is_af: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_ready |-> almost_full);

    // R7: crossing pointers change one bit per edge
    a_r7_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);
    a_r7_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind xfp_fifo xfp_fifo_chk #(.AW(AW), .DW(WIDTH)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .fwft_mode   (fwft_mode),
    .wr_en       (wr_en),
    .wr_ready    (wr_ready),
    .almost_full (almost_full),
    .rd_en       (rd_en),
    .rd_ready    (rd_ready),
    .almost_empty(almost_empty),
    .rd_data     (rd_data),
    .w_bin       (w_bin),
    .r_bin       (r_bin),
    .w_gray      (w_gray),
    .r_gray      (r_gray)
);

// File: tb/tb_xfp_fifo.sv
module tb_xfp_fifo;
    localparam int DEPTH = 128;
    localparam int W     = 36;
    localparam int PROG_AE = 5;
    localparam int PROG_AF = 100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fwft_mode = 1'b0;
    logic [1:0]   ofs_sel = 2'b00;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         wr_ready, almost_full, rd_ready, almost_empty;
    logic [W-1:0] rd_data;

    int errors = 0;
    int checks = 0;

    logic [W-1:0] mq [0:511];
    int head, tail;
    int ae_o, af_o;
    logic [W-1:0] last_out;

    always #5 clk = ~clk;

    xfp_fifo #(.DEPTH(DEPTH)) dut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
        .ofs_sel(ofs_sel), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .almost_full(almost_full), .rd_en(rd_en),
        .rd_data(rd_data), .rd_ready(rd_ready), .almost_empty(almost_empty)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lvl();
        return tail - head;
    endfunction

    function automatic int memcnt();
        if (fwft_mode && lvl() > 0) return lvl() - 1;
        return lvl();
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode, input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0; fwft_mode = mode; ofs_sel = sel; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        head = 0; tail = 0; last_out = '0;
        case (sel)
            2'b01:   begin ae_o = 16; af_o = 16; end
            2'b10:   begin ae_o = 64; af_o = 64; end
            default: begin ae_o = 8;  af_o = 8;  end
        endcase
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_ready", rd_ready, 0);
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 almost_full", almost_full, 0);
    endtask

    task automatic flags(input string tag);
        chk({tag, " R7/R8 rd_ready"}, rd_ready, lvl() > 0);
        chk({tag, " R10 wr_ready"}, wr_ready, memcnt() < DEPTH);
        chk({tag, " R9 almost_empty"}, almost_empty, lvl() <= ae_o);
        chk({tag, " R10 almost_full"}, almost_full, (DEPTH - memcnt()) <= af_o);
    endtask

    task automatic push(input logic [W-1:0] d);
        logic acc;
        acc = (memcnt() < DEPTH);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (acc) begin mq[tail % 512] = d; tail++; end
        settle();
        flags(acc ? "R4 push" : "R5 push-full");
    endtask

    task automatic pop();
        logic had;
        had = (lvl() > 0);
        if (fwft_mode && had) chk("R8 head on outputs", rd_data, mq[head % 512]);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (had) begin last_out = mq[head % 512]; head++; end
        settle();
        if (!fwft_mode && had) chk("R4 read data", rd_data, last_out);
        if (!had)              chk("R6 ignored read data", rd_data, last_out);
        flags(had ? "R4 pop" : "R6 pop-empty");
    endtask

    task automatic run_cfg(input logic mode, input logic [1:0] sel);
        do_reset(mode, sel);
        if (sel == 2'b11) begin
            // R3: two loading writes, not stored
            @(negedge clk); wr_en = 1'b1; wr_data = W'(PROG_AE);
            @(negedge clk); wr_data = W'(PROG_AF);
            @(negedge clk); wr_en = 1'b0;
            ae_o = PROG_AE; af_o = PROG_AF;
            settle();
            chk("R3 loads not stored", rd_ready, 0);
        end
        for (int i = 0; i < DEPTH + 3; i++)
            push({2'(sel), 1'(mode), 1'b1, 32'(i * 32'h9E3779B1 + 7)});
        for (int i = 0; i < DEPTH + 3; i++)
            pop();
    endtask

    task automatic latency(input logic mode);
        logic [W-1:0] d;
        d = 36'hA_5C3E_0F17;
        do_reset(mode, 2'b00);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;          // after write edge E0
        chk("R7 rd_ready E0", rd_ready, 0);
        @(negedge clk); chk("R7 rd_ready E1", rd_ready, 0);
        @(negedge clk); chk(mode ? "R8 rd_ready E2" : "R7 rd_ready E2", rd_ready, !mode);
        @(negedge clk); chk(mode ? "R8 rd_ready E3" : "R7 rd_ready E3", rd_ready, 1);
        if (mode) chk("R8 word without read", rd_data, d);
        else      chk("R7 no data without read", rd_data, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        latency(1'b0);
        latency(1'b1);
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                run_cfg(1'(m), 2'(s));   // R2 defaults, R3 load
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule